// File: doc/BRIEF.md
# Debug Trace Capture Buffer

This block is the storage end of an on-chip debug unit. While the arm bit is set it records either 16-bit change-of-flow addresses or 8-bit event bytes from a bus monitor into a shift-register buffer. The buffer is eight words deep by default. A valid-word count is reported alongside. A host empties the buffer through two byte views of the word at the output end. Reading the low byte moves the buffer on by one word. In address modes the high byte must be read before the low byte so that the two halves belong to the same word.

Captured words pass through a short delay pipeline before they are stored. In begin-trigger mode, the change-of-flow address seen in the trigger cycle is dropped, and so are those seen in the cycles the pipeline needs to fill. In end-trigger mode the block records continuously and keeps the newest words. A change-of-flow address that coincides with the end trigger becomes the last word of the run.

When the arm bit is clear, the buffer samples the program counter for profiling: every low-byte read pushes in the address of the most recent opcode fetch. If the host stops a run before the buffer has filled, the contents end up one place further along, and the host has to skip words to reach the first one that was captured.

Top module: `trace_fifo`

## Requirements
- R1: After reset the count is 0, both data views read 0, and the block is disarmed.
- R2: A rising edge of `arm` empties every entry and sets the count to 0 on the next clock.
- R3: In begin mode (`mode`=2'b00; 2'b11 acts the same), the change-of-flow address in the trigger cycle and in the next SKIP (default 2) cycles is not stored. Addresses after that are stored, and the host reads them back in the order they were stored. The count rises by at most one per clock.
- R4: In begin and event modes, once the count reaches DEPTH no further word is stored. The count saturates at DEPTH and never wraps.
- R5: In end mode (`mode`=2'b01), storing starts at arm and keeps the newest DEPTH words. The address present in the `trig_end` cycle is stored as the last word, and nothing is stored after it.
- R6: In event mode (`mode`=2'b10), `evt_data` bytes are stored, `data_hi` reads 0, and each low read advances to the next byte.
- R7: A `rd_lo` pulse shifts the buffer one word toward the output. While armed it also lowers a non-zero count by one.
- R8: A `rd_hi` pulse latches the low byte of the current output word. `data_lo` shows that latched byte until the next `rd_lo`, even if new words shift in before then.
- R9: Clearing `arm` while the count is below DEPTH shifts the buffer one extra place. After (DEPTH − count − 1) low reads, the first captured word is at the output.
- R10: While disarmed, each `rd_lo` pushes `fetch_addr` into the buffer. The value pushed at read n is shown at the output after read n+DEPTH−1. The count is left unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | Capture enable (arm bit) |
| mode | input | 2 | 00 begin, 01 end, 10 event, 11 begin |
| trig_begin | input | 1 | Begin trigger has fired |
| trig_end | input | 1 | End trigger has fired |
| cof_vld | input | 1 | Change-of-flow address strobe |
| cof_addr | input | 2*BW | Change-of-flow address |
| evt_vld | input | 1 | Event data strobe |
| evt_data | input | BW | Event data byte |
| fetch_addr | input | 2*BW | Address of the most recent opcode fetch |
| rd_hi | input | 1 | Host read of the high byte |
| rd_lo | input | 1 | Host read of the low byte (advances the buffer) |
| data_hi | output | BW | High byte of the output word |
| data_lo | output | BW | Low byte of the output word, or the latched low byte |
| count | output | clog2(DEPTH+1) | Number of valid words |

## Verification
The bench uses the default parameters: DEPTH of 8, a SKIP delay of 2 and 8-bit halves. With these values a saturated buffer, the overflow attempt that follows it, and the dummy-read formula after a stop at count 3 all take only a few dozen cycles. A delay of 2 makes the trigger cycle plus two dropped cycles visible as a precise window: the first word stored is the one that arrives in the third cycle after the trigger. Nine profiling reads show the DEPTH−1 read lag and confirm that the count stays constant while disarmed.

// File: rtl/trace_pkg.sv
package trace_pkg;
   typedef enum logic [1:0] {
      TM_COF_BEGIN = 2'b00,
      TM_COF_END   = 2'b01,
      TM_EVENT     = 2'b10,
      TM_RESERVED  = 2'b11
   } trace_mode_e;
endpackage

// File: rtl/trace_capture_gate.sv
// Decides which monitor strobes enter the delay pipeline: start/stop state
// plus the post-trigger suppress window.
module trace_capture_gate
   import trace_pkg::*;
#(
   parameter int unsigned AW   = 16,
   parameter int unsigned BW   = 8,
   parameter int unsigned SKIP = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          arm_rise,
   input  logic          armed,
   input  trace_mode_e   mode,
   input  logic          trig_begin,
   input  logic          trig_end,
   input  logic          cof_vld,
   input  logic [AW-1:0] cof_addr,
   input  logic          evt_vld,
   input  logic [BW-1:0] evt_data,
   output logic          acc_vld,
   output logic [AW-1:0] acc_data
);
   localparam int unsigned SW = $clog2(SKIP + 1);

   logic          started;
   logic          stopped;
   logic [SW-1:0] supp;
   logic          is_event;
   logic          is_end;
   logic          is_begin;
   logic          open_q;

   assign is_event = (mode == TM_EVENT);
   assign is_end   = (mode == TM_COF_END);
   assign is_begin = !is_event && !is_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         started <= 1'b0;
         stopped <= 1'b0;
         supp    <= '0;
      end else if (arm_rise) begin
         started <= !is_begin;
         stopped <= 1'b0;
         supp    <= '0;
      end else if (armed) begin
         if (is_begin && !started && trig_begin) begin
            started <= 1'b1;
            supp    <= SW'(SKIP);
         end else if (started && (supp != '0)) begin
            supp    <= supp - 1'b1;
         end
         if (is_end && started && !stopped && trig_end) begin
            stopped <= 1'b1;
         end
      end
   end

   assign open_q   = armed && started && !stopped && (supp == '0);
   assign acc_vld  = open_q && (is_event ? evt_vld : cof_vld);
   assign acc_data = is_event ? {{(AW-BW){1'b0}}, evt_data} : cof_addr;
endmodule

// File: rtl/trace_delay_pipe.sv
// Fixed-latency input pipeline between the capture gate and the buffer.
module trace_delay_pipe #(
   parameter int unsigned W      = 16,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         flush,
   input  logic         in_vld,
   input  logic [W-1:0] in_data,
   output logic         out_vld,
   output logic [W-1:0] out_data
);
   logic         vld [STAGES];
   logic [W-1:0] dat [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  vld[0] <= 1'b0;
                  dat[0] <= '0;
               end else begin
                  vld[0] <= flush ? 1'b0 : in_vld;
                  dat[0] <= in_data;
               end
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  vld[s] <= 1'b0;
                  dat[s] <= '0;
               end else begin
                  vld[s] <= flush ? 1'b0 : vld[s-1];
                  dat[s] <= dat[s-1];
               end
            end
         end
      end
   endgenerate

   assign out_vld  = vld[STAGES-1];
   assign out_data = dat[STAGES-1];
endmodule

// File: rtl/trace_shift_buf.sv
// Shift-register storage: words enter at the tail and move toward entry 0.
module trace_shift_buf #(
   parameter int unsigned AW    = 16,
   parameter int unsigned DEPTH = 8,
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          shift,
   input  logic [AW-1:0] tail_in,
   input  logic          cnt_inc,
   input  logic          cnt_dec,
   output logic [AW-1:0] head,
   output logic [CW-1:0] count
);
   logic [AW-1:0] mem [DEPTH];
   logic          inc_ok;
   logic          dec_ok;

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_ent
         if (i == DEPTH - 1) begin : g_tail
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)      mem[i] <= '0;
               else if (clear)  mem[i] <= '0;
               else if (shift)  mem[i] <= tail_in;
            end
         end else begin : g_body
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)      mem[i] <= '0;
               else if (clear)  mem[i] <= '0;
               else if (shift)  mem[i] <= mem[i+1];
            end
         end
      end
   endgenerate

   assign inc_ok = cnt_inc && (count != CW'(DEPTH));
   assign dec_ok = cnt_dec && (count != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                count <= '0;
      else if (clear)            count <= '0;
      else if (inc_ok && !dec_ok) count <= count + 1'b1;
      else if (dec_ok && !inc_ok) count <= count - 1'b1;
   end

   assign head = mem[0];
endmodule

// File: rtl/trace_fifo.sv
// Debug trace capture buffer top: arm control, store gating, host read views.
module trace_fifo
   import trace_pkg::*;
#(
   parameter int unsigned BW    = 8,
   parameter int unsigned DEPTH = 8,
   parameter int unsigned SKIP  = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       arm,
   input  logic [1:0]                 mode,
   input  logic                       trig_begin,
   input  logic                       trig_end,
   input  logic                       cof_vld,
   input  logic [2*BW-1:0]            cof_addr,
   input  logic                       evt_vld,
   input  logic [BW-1:0]              evt_data,
   input  logic [2*BW-1:0]            fetch_addr,
   input  logic                       rd_hi,
   input  logic                       rd_lo,
   output logic [BW-1:0]              data_hi,
   output logic [BW-1:0]              data_lo,
   output logic [$clog2(DEPTH+1)-1:0] count
);
   localparam int unsigned AW = 2 * BW;
   localparam int unsigned CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("trace_fifo: DEPTH must be at least 2");
      end
      if (SKIP < 1) begin : g_bad_skip
         $error("trace_fifo: SKIP must be at least 1");
      end
      if (BW < 1) begin : g_bad_bw
         $error("trace_fifo: BW must be at least 1");
      end
   endgenerate

   trace_mode_e   mode_e;
   logic          arm_q;
   logic          arm_rise;
   logic          halt;
   logic          armed;
   logic          idle_prof;
   logic          is_event;
   logic          is_end;
   logic          acc_vld;
   logic [AW-1:0] acc_data;
   logic          st_vld;
   logic [AW-1:0] st_data;
   logic          store;
   logic          halt_shift;
   logic          shift;
   logic [AW-1:0] tail_in;
   logic [AW-1:0] head;
   logic [BW-1:0] lo_hold;
   logic          hold_vld;

   assign mode_e    = trace_mode_e'(mode);
   assign is_event  = (mode_e == TM_EVENT);
   assign is_end    = (mode_e == TM_COF_END);
   assign arm_rise  = arm && !arm_q;
   assign halt      = !arm && arm_q;
   assign armed     = arm && arm_q;
   assign idle_prof = !arm && !arm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) arm_q <= 1'b0;
      else        arm_q <= arm;
   end

   trace_capture_gate #(.AW(AW), .BW(BW), .SKIP(SKIP)) u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .arm_rise  (arm_rise),
      .armed     (armed),
      .mode      (mode_e),
      .trig_begin(trig_begin),
      .trig_end  (trig_end),
      .cof_vld   (cof_vld),
      .cof_addr  (cof_addr),
      .evt_vld   (evt_vld),
      .evt_data  (evt_data),
      .acc_vld   (acc_vld),
      .acc_data  (acc_data)
   );

   trace_delay_pipe #(.W(AW), .STAGES(SKIP)) u_pipe (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (arm_rise || halt),
      .in_vld  (acc_vld),
      .in_data (acc_data),
      .out_vld (st_vld),
      .out_data(st_data)
   );

   assign store      = st_vld && armed && ((count != CW'(DEPTH)) || is_end);
   assign halt_shift = halt && (count != CW'(DEPTH));
   assign shift      = store || rd_lo || halt_shift;

   always_comb begin
      if (store)          tail_in = st_data;
      else if (idle_prof) tail_in = fetch_addr;
      else                tail_in = '0;
   end

   trace_shift_buf #(.AW(AW), .DEPTH(DEPTH)) u_buf (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (arm_rise),
      .shift  (shift),
      .tail_in(tail_in),
      .cnt_inc(store),
      .cnt_dec(rd_lo && armed),
      .head   (head),
      .count  (count)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_hold  <= '0;
         hold_vld <= 1'b0;
      end else if (arm_rise || rd_lo) begin
         hold_vld <= 1'b0;
      end else if (rd_hi) begin
         lo_hold  <= head[BW-1:0];
         hold_vld <= 1'b1;
      end
   end

   assign data_hi = is_event ? '0 : head[AW-1:BW];
   assign data_lo = hold_vld ? lo_hold : head[BW-1:0];
endmodule

// File: rtl/trace_fifo_chk.sv
module trace_fifo_chk #(
   parameter int unsigned BW    = 8,
   parameter int unsigned DEPTH = 8,
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          arm,
   input logic          arm_q,
   input logic [1:0]    mode,
   input logic          rd_hi,
   input logic          rd_lo,
   input logic          hold_vld,
   input logic [BW-1:0] data_hi,
   input logic [BW-1:0] data_lo,
   input logic [CW-1:0] count
);
   assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));

   assert_full_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (count == CW'(DEPTH)) && arm && arm_q && !rd_lo && !rd_hi && (mode != 2'b01)
      |=> $stable(count) && $stable(data_lo));

   assert_arm_empties_R2: assert property (@(posedge clk) disable iff (!rst_n)
      arm && !arm_q |=> (count == '0));

   assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (count > $past(count)) |-> ((count - $past(count)) == CW'(1)));

   assert_idle_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !arm && !arm_q |=> $stable(count));

   assert_hi_latches_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hi && !rd_lo && !hold_vld && !(arm && !arm_q) |=> (data_lo == $past(data_lo)));

   assert_hold_stays_R8: assert property (@(posedge clk) disable iff (!rst_n)
      hold_vld && !rd_lo && !rd_hi && !(arm && !arm_q) |=> $stable(data_lo));
endmodule

bind trace_fifo trace_fifo_chk #(.BW(BW), .DEPTH(DEPTH)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .arm     (arm),
   .arm_q   (arm_q),
   .mode    (mode),
   .rd_hi   (rd_hi),
   .rd_lo   (rd_lo),
   .hold_vld(hold_vld),
   .data_hi (data_hi),
   .data_lo (data_lo),
   .count   (count)
);

// File: tb/sim_trace_fifo.sv
`timescale 1ns/1ps
module sim_trace_fifo;
   localparam int BW = 8;
   localparam int DEPTH = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        arm = 1'b0;
   logic [1:0]  mode = 2'b00;
   logic        trig_begin = 1'b0;
   logic        trig_end = 1'b0;
   logic        cof_vld = 1'b0;
   logic [15:0] cof_addr = '0;
   logic        evt_vld = 1'b0;
   logic [7:0]  evt_data = '0;
   logic [15:0] fetch_addr = '0;
   logic        rd_hi = 1'b0;
   logic        rd_lo = 1'b0;
   logic [7:0]  data_hi;
   logic [7:0]  data_lo;
   logic [3:0]  count;

   int checks = 0;
   int failures = 0;

   always #4 clk = ~clk;

   trace_fifo #(.BW(BW), .DEPTH(DEPTH), .SKIP(2)) u0 (
      .clk(clk), .rst_n(rst_n), .arm(arm), .mode(mode),
      .trig_begin(trig_begin), .trig_end(trig_end),
      .cof_vld(cof_vld), .cof_addr(cof_addr),
      .evt_vld(evt_vld), .evt_data(evt_data),
      .fetch_addr(fetch_addr), .rd_hi(rd_hi), .rd_lo(rd_lo),
      .data_hi(data_hi), .data_lo(data_lo), .count(count)
   );

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic settle();
      repeat (4) tick();
   endtask

   task automatic arm_up(logic [1:0] m);
      arm = 1'b0;
      tick();
      mode = m;
      arm = 1'b1;
      tick();
   endtask

   task automatic push_cof(logic [15:0] a, logic tb, logic te);
      cof_vld = 1'b1; cof_addr = a; trig_begin = tb; trig_end = te;
      tick();
      cof_vld = 1'b0; trig_begin = 1'b0; trig_end = 1'b0;
   endtask

   task automatic push_evt(logic [7:0] d);
      evt_vld = 1'b1; evt_data = d;
      tick();
      evt_vld = 1'b0;
   endtask

   task automatic pulse_lo();
      rd_lo = 1'b1; tick(); rd_lo = 1'b0;
   endtask

   task automatic read_word(string req, logic [15:0] exp);
      chk({req, " hi"}, 16'(data_hi), 16'(exp[15:8]));
      chk({req, " lo"}, 16'(data_lo), 16'(exp[7:0]));
      rd_hi = 1'b1; tick(); rd_hi = 1'b0;
      pulse_lo();
   endtask

   task automatic t_reset();
      chk("R1 count", 16'(count), 16'd0);
      chk("R1 data_hi", 16'(data_hi), 16'd0);
      chk("R1 data_lo", 16'(data_lo), 16'd0);
   endtask

   task automatic t_begin();
      arm_up(2'b00);
      chk("R2 count after arm", 16'(count), 16'd0);
      push_cof(16'hDEAD, 1'b1, 1'b0);
      push_cof(16'hBAD1, 1'b0, 1'b0);
      push_cof(16'hBAD2, 1'b0, 1'b0);
      for (int i = 0; i < DEPTH; i++) push_cof(16'hA000 + 16'(i) * 16'h0111, 1'b0, 1'b0);
      push_cof(16'hFFFF, 1'b0, 1'b0);
      settle();
      chk("R4 count saturates", 16'(count), 16'(DEPTH));
      for (int i = 0; i < DEPTH; i++) begin
         chk("R7 count before read", 16'(count), 16'(DEPTH - i));
         read_word("R3 order", 16'hA000 + 16'(i) * 16'h0111);
      end
      chk("R7 count drained", 16'(count), 16'd0);
   endtask

   task automatic t_event();
      arm_up(2'b10);
      for (int i = 0; i < DEPTH; i++) push_evt(8'h30 + 8'(i));
      push_evt(8'hEE);
      settle();
      chk("R4 event full", 16'(count), 16'(DEPTH));
      for (int i = 0; i < DEPTH; i++) begin
         chk("R6 hi unused", 16'(data_hi), 16'd0);
         chk("R6 byte", 16'(data_lo), 16'(8'h30 + 8'(i)));
         pulse_lo();
      end
      chk("R4 overflow byte dropped", 16'(count), 16'd0);
   endtask

   task automatic t_end();
      arm_up(2'b01);
      for (int i = 0; i < 10; i++) push_cof(16'hC000 + 16'(i), 1'b0, i == 9);
      push_cof(16'h7777, 1'b0, 1'b0);
      settle();
      chk("R5 count", 16'(count), 16'(DEPTH));
      for (int i = 0; i < DEPTH; i++) read_word("R5 newest kept", 16'hC002 + 16'(i));
      chk("R5 nothing after end", 16'(count), 16'd0);
      chk("R5 tail empty", 16'(data_lo), 16'd0);
   endtask

   task automatic t_hold();
      logic [15:0] f [10];
      for (int i = 0; i < 10; i++) f[i] = {8'h10 + 8'(i), 8'h80 + 8'(i)};
      arm_up(2'b01);
      for (int i = 0; i < DEPTH; i++) push_cof(f[i], 1'b0, 1'b0);
      settle();
      rd_hi = 1'b1; tick(); rd_hi = 1'b0;
      push_cof(16'h4321, 1'b0, 1'b0);
      settle();
      chk("R8 hi follows head", 16'(data_hi), 16'(f[1][15:8]));
      chk("R8 lo latched", 16'(data_lo), 16'(f[0][7:0]));
      pulse_lo();
      chk("R8 lo released", 16'(data_lo), 16'(f[2][7:0]));
      chk("R7 armed decrement", 16'(count), 16'(DEPTH - 1));
   endtask

   task automatic t_skew();
      arm_up(2'b00);
      push_cof(16'h1111, 1'b1, 1'b0);
      push_cof(16'h2222, 1'b0, 1'b0);
      push_cof(16'h3333, 1'b0, 1'b0);
      for (int i = 0; i < 3; i++) push_cof({8'h60 + 8'(i), 8'h90 + 8'(i)}, 1'b0, 1'b0);
      settle();
      chk("R9 partial count", 16'(count), 16'd3);
      arm = 1'b0;
      tick();
      chk("R9 count after halt", 16'(count), 16'd3);
      fetch_addr = 16'h0F0F;
      repeat (DEPTH - 3 - 1) pulse_lo();
      for (int i = 0; i < 3; i++) read_word("R9 after dummies", {8'h60 + 8'(i), 8'h90 + 8'(i)});
   endtask

   task automatic t_profile();
      for (int i = 0; i < DEPTH; i++) begin
         fetch_addr = 16'h8000 + 16'(i) * 16'h0123;
         pulse_lo();
      end
      chk("R10 first sample hi", 16'(data_hi), 16'h80);
      chk("R10 first sample lo", 16'(data_lo), 16'h00);
      fetch_addr = 16'h8000 + 16'(DEPTH) * 16'h0123;
      pulse_lo();
      chk("R10 second sample", {data_hi, data_lo}, 16'h8123);
      chk("R10 count unchanged", 16'(count), 16'd3);
   endtask

   task automatic t_rearm();
      arm_up(2'b00);
      chk("R2 rearm count", 16'(count), 16'd0);
      chk("R2 rearm hi", 16'(data_hi), 16'd0);
      chk("R2 rearm lo", 16'(data_lo), 16'd0);
   endtask

   initial begin
      #(8 * 50000);
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) tick();
      t_reset();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_begin();
      t_event();
      t_end();
      t_hold();
      t_skew();
      t_profile();
      t_rearm();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule